// File: doc/BRIEF.md
# Merged-State Multi-Pattern String Matcher

This block scans a byte stream against a set of fixed strings, one character per cycle. It walks a compressed multi-pattern automaton in which states that several patterns would otherwise duplicate are shared. Each state carries a per-pattern path vector and a final flag. A path register records which patterns the walk so far can still belong to. When the walk reaches a final state, the path register tells apart the patterns that share that state. As a result, a shared suffix does not report a pattern whose prefix was never seen.

Two tables make up the automaton. The transition table maps a (state, character) pair to a next state. It sits at a slot computed from the key and is confirmed by a stored key tag. The state table holds, for each state, a failure state, a path vector and a final flag. Both tables are loaded through one write port while the input stream is idle. The tables are built offline, and that step also places transitions so that no two keys share a slot.

Top module: `acm_match_engine`

## Requirements
- R1: After reset, state_o is the root state 0, path_o is all zero, and match_vld_o and match_o are zero.
- R2: A write with cfg_tbl_i=0 stores the transition (cfg_src_i, cfg_chr_i) -> cfg_nxt_i at slot ((cfg_src_i << 3) XOR cfg_chr_i) mod 2^TT_AW. A lookup hits only if both the source state and the character equal the stored key, so another key that maps to the same slot misses. A write with cfg_tbl_i=1 stores cfg_fail_i, cfg_path_i and cfg_final_i for state cfg_src_i.
- R3: On an accepted character with a transition from the current state while path_o is non-zero, the walk moves to the next state, and path_o becomes its old value AND the next state's path vector.
- R4: On an accepted character with a transition from the current state while path_o is zero, path_o loads the next state's path vector unchanged.
- R5: If no transition exists from the current state and path_o is non-zero, the character is retried from that state's failure state in the same cycle. On a hit the walk enters the target with path_o set to the target's path vector. On a miss it returns to root with path_o cleared.
- R6: If no transition exists from the current state and path_o is zero, the character is retried from root. A miss there leaves the walk at root with path_o cleared.
- R7: In the cycle after an accepted character, match_vld_o is 1 exactly when the entered state has its final flag set and the new path_o is non-zero. In that case match_o equals the new path_o; otherwise match_o is zero.
- R8: With pattern bit 0 = "bcdf" and pattern bit 1 = "pcdg" sharing states for "cd", the input "pcdf" reports no match and "pcdg" reports match_o = 4'b0010.
- R9: A cycle with chr_vld_i low leaves state_o and path_o unchanged, and match_vld_o is 0 in the following cycle.
- R10: cfg_we_i and chr_vld_i are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_we_i | input | 1 | Table write strobe |
| cfg_tbl_i | input | 1 | 0 selects the transition table, 1 the state table |
| cfg_src_i | input | SW | Source state (transition) or state index (state table) |
| cfg_chr_i | input | 8 | Transition character |
| cfg_nxt_i | input | SW | Transition next state |
| cfg_fail_i | input | SW | Failure state of the indexed state |
| cfg_path_i | input | NP | Path vector of the indexed state |
| cfg_final_i | input | 1 | Final flag of the indexed state |
| chr_vld_i | input | 1 | Input character valid |
| chr_i | input | 8 | Input character |
| state_o | output | SW | Current state |
| path_o | output | NP | Path register |
| match_vld_o | output | 1 | Match reported for the last character |
| match_o | output | NP | Matched pattern vector |

## Verification
The bench builds the engine with NP=4, SW=5 and TT_AW=6. At this size every slot address can be worked out by hand. That lets the bench place a key, 'k' at root, that lands on the occupied slot of a different key, so the tag check is exercised. The table holds two patterns that share the "cd" states and a third pattern, "dq", that is reached through a failure link. With that table, short strings reach the false-positive case of the shared suffix, the path-zero restart from a dead end, and a match found after a failure hop. A behavioural model of the walk, held in associative arrays, is compared with all outputs after every clock.

// File: rtl/acm_pkg.sv
package acm_pkg;
  localparam int CHAR_W = 8;
  localparam int SLOT_SHIFT = 3;
endpackage

// File: rtl/acm_trans_tbl.sv
module acm_trans_tbl
  import acm_pkg::*;
#(
  parameter int SW    = 10,
  parameter int TT_AW = 11
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [SW-1:0]     wr_src_i,
  input  logic [CHAR_W-1:0] wr_chr_i,
  input  logic [SW-1:0]     wr_nxt_i,
  input  logic [SW-1:0]     rd_src_i [2],
  input  logic [CHAR_W-1:0] rd_chr_i [2],
  output logic              rd_hit_o [2],
  output logic [SW-1:0]     rd_nxt_o [2]
);
  localparam int DEPTH = 1 << TT_AW;

  logic [SW-1:0]     src_m [DEPTH];
  logic [CHAR_W-1:0] chr_m [DEPTH];
  logic [SW-1:0]     nxt_m [DEPTH];
  logic [DEPTH-1:0]  used_q;

  function automatic logic [TT_AW-1:0] slot_f(input logic [SW-1:0] s, input logic [CHAR_W-1:0] c);
    logic [31:0] h;
    h = (32'(s) << SLOT_SHIFT) ^ 32'(c);
    return h[TT_AW-1:0];
  endfunction

  logic [TT_AW-1:0] wr_slot;
  assign wr_slot = slot_f(wr_src_i, wr_chr_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   used_q <= '0;
    else if (we_i) used_q[wr_slot] <= 1'b1;
  end

  always_ff @(posedge clk_i) begin
    if (we_i) begin
      src_m[wr_slot] <= wr_src_i;
      chr_m[wr_slot] <= wr_chr_i;
      nxt_m[wr_slot] <= wr_nxt_i;
    end
  end

  for (genvar p = 0; p < 2; p++) begin : g_port
    logic [TT_AW-1:0] rslot;
    assign rslot       = slot_f(rd_src_i[p], rd_chr_i[p]);
    // tag compare rejects a different key sharing the slot
    assign rd_hit_o[p] = used_q[rslot] && (src_m[rslot] == rd_src_i[p])
                         && (chr_m[rslot] == rd_chr_i[p]);
    assign rd_nxt_o[p] = nxt_m[rslot];
  end
endmodule

// File: rtl/acm_state_tbl.sv
module acm_state_tbl #(
  parameter int SW = 10,
  parameter int NP = 32
) (
  input  logic          clk_i,
  input  logic          we_i,
  input  logic [SW-1:0] wr_state_i,
  input  logic [SW-1:0] wr_fail_i,
  input  logic [NP-1:0] wr_path_i,
  input  logic          wr_fin_i,
  input  logic [SW-1:0] cur_state_i,
  output logic [SW-1:0] cur_fail_o,
  input  logic [SW-1:0] dst_state_i,
  output logic [NP-1:0] dst_path_o,
  output logic          dst_fin_o
);
  localparam int NSTATES = 1 << SW;

  logic [SW-1:0] fail_m [NSTATES];
  logic [NP-1:0] path_m [NSTATES];
  logic          fin_m  [NSTATES];

  always_ff @(posedge clk_i) begin
    if (we_i) begin
      fail_m[wr_state_i] <= wr_fail_i;
      path_m[wr_state_i] <= wr_path_i;
      fin_m[wr_state_i]  <= wr_fin_i;
    end
  end

  assign cur_fail_o = fail_m[cur_state_i];
  assign dst_path_o = path_m[dst_state_i];
  assign dst_fin_o  = fin_m[dst_state_i];
endmodule

// File: rtl/acm_match_engine.sv
module acm_match_engine
  import acm_pkg::*;
#(
  parameter int NP    = 32,
  parameter int SW    = 10,
  parameter int TT_AW = 11
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cfg_we_i,
  input  logic              cfg_tbl_i,
  input  logic [SW-1:0]     cfg_src_i,
  input  logic [CHAR_W-1:0] cfg_chr_i,
  input  logic [SW-1:0]     cfg_nxt_i,
  input  logic [SW-1:0]     cfg_fail_i,
  input  logic [NP-1:0]     cfg_path_i,
  input  logic              cfg_final_i,
  input  logic              chr_vld_i,
  input  logic [CHAR_W-1:0] chr_i,
  output logic [SW-1:0]     state_o,
  output logic [NP-1:0]     path_o,
  output logic              match_vld_o,
  output logic [NP-1:0]     match_o
);
  localparam logic [SW-1:0] ROOT = '0;

  logic [SW-1:0] state_q;
  logic [NP-1:0] path_q, match_q;
  logic          match_vld_q;

  logic [SW-1:0]     rd_src [2];
  logic [CHAR_W-1:0] rd_chr [2];
  logic              rd_hit [2];
  logic [SW-1:0]     rd_nxt [2];

  logic          path_nz, ns_sel, hit_a, hit_b, dst_fin, any_hit, mhit;
  logic [SW-1:0] cur_fail, retry_st, dst;
  logic [NP-1:0] dst_path, path_nx;

  assign path_nz  = |path_q;
  assign hit_a    = rd_hit[0];
  assign hit_b    = rd_hit[1];
  // ns_sel=1: live path and no direct transition -> retry via failure link
  assign ns_sel   = path_nz & ~hit_a;
  assign retry_st = ns_sel ? cur_fail : ROOT;

  assign rd_src[0] = state_q;
  assign rd_chr[0] = chr_i;
  assign rd_src[1] = retry_st;
  assign rd_chr[1] = chr_i;

  acm_trans_tbl #(.SW(SW), .TT_AW(TT_AW)) u_trans (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .we_i     (cfg_we_i & ~cfg_tbl_i),
    .wr_src_i (cfg_src_i),
    .wr_chr_i (cfg_chr_i),
    .wr_nxt_i (cfg_nxt_i),
    .rd_src_i (rd_src),
    .rd_chr_i (rd_chr),
    .rd_hit_o (rd_hit),
    .rd_nxt_o (rd_nxt)
  );

  assign dst = hit_a ? rd_nxt[0] : (hit_b ? rd_nxt[1] : ROOT);

  acm_state_tbl #(.SW(SW), .NP(NP)) u_state (
    .clk_i       (clk_i),
    .we_i        (cfg_we_i & cfg_tbl_i),
    .wr_state_i  (cfg_src_i),
    .wr_fail_i   (cfg_fail_i),
    .wr_path_i   (cfg_path_i),
    .wr_fin_i    (cfg_final_i),
    .cur_state_i (state_q),
    .cur_fail_o  (cur_fail),
    .dst_state_i (dst),
    .dst_path_o  (dst_path),
    .dst_fin_o   (dst_fin)
  );

  always_comb begin
    if (hit_a)      path_nx = path_nz ? (path_q & dst_path) : dst_path;
    else if (hit_b) path_nx = dst_path;
    else            path_nx = '0;
  end

  assign any_hit = hit_a | hit_b;
  assign mhit    = any_hit & dst_fin & (|path_nx);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q     <= ROOT;
      path_q      <= '0;
      match_vld_q <= 1'b0;
      match_q     <= '0;
    end else if (chr_vld_i) begin
      state_q     <= dst;
      path_q      <= path_nx;
      match_vld_q <= mhit;
      match_q     <= mhit ? path_nx : '0;
    end else begin
      match_vld_q <= 1'b0;
      match_q     <= '0;
    end
  end

  assign state_o     = state_q;
  assign path_o      = path_q;
  assign match_vld_o = match_vld_q;
  assign match_o     = match_q;

  p_narrow_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (chr_vld_i && hit_a && path_nz) |=> ((path_q & ~$past(path_q)) == '0));

  p_miss_root_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (chr_vld_i && !hit_a && !hit_b) |=> (state_q == ROOT && path_q == '0));

  p_match_path_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    match_vld_o |-> (match_o == path_o && match_o != '0));

  p_idle_hold_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !chr_vld_i |=> ($stable(state_o) && $stable(path_o) && !match_vld_o));

  p_cfg_idle_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(cfg_we_i && chr_vld_i));
endmodule

// File: tb/acm_match_engine_tb.sv
`timescale 1ns/1ps
module acm_match_engine_tb_top;
  localparam int NP = 4;
  localparam int SW = 5;
  localparam int TT_AW = 6;

  logic          clk = 1'b0;
  logic          rst_ni = 1'b0;
  logic          cfg_we = 1'b0, cfg_tbl = 1'b0, cfg_final = 1'b0;
  logic [SW-1:0] cfg_src = '0, cfg_nxt = '0, cfg_fail = '0;
  logic [7:0]    cfg_chr = '0;
  logic [NP-1:0] cfg_path = '0;
  logic          chr_vld = 1'b0;
  logic [7:0]    chr = '0;
  logic [SW-1:0] state_o;
  logic [NP-1:0] path_o, match_o;
  logic          match_vld_o;

  int checks = 0, fails = 0;
  bit done = 0;

  always #10 clk = ~clk;

  acm_match_engine #(.NP(NP), .SW(SW), .TT_AW(TT_AW)) dut_i (
    .clk_i(clk), .rst_ni(rst_ni),
    .cfg_we_i(cfg_we), .cfg_tbl_i(cfg_tbl), .cfg_src_i(cfg_src), .cfg_chr_i(cfg_chr),
    .cfg_nxt_i(cfg_nxt), .cfg_fail_i(cfg_fail), .cfg_path_i(cfg_path), .cfg_final_i(cfg_final),
    .chr_vld_i(chr_vld), .chr_i(chr),
    .state_o(state_o), .path_o(path_o), .match_vld_o(match_vld_o), .match_o(match_o)
  );

  // behavioural model
  int            go_m [int];
  int            fl_m [int];
  logic [NP-1:0] pv_m [int];
  bit            fn_m [int];
  int            m_st = 0;
  logic [NP-1:0] m_path = '0, m_mvec = '0;
  bit            m_mvld = 0;

  task automatic model_step(input bit v, input logic [7:0] c);
    int k, d, r;
    bit hit;
    logic [NP-1:0] np;
    if (!v) begin m_mvld = 0; m_mvec = '0; return; end
    k = m_st * 256 + int'(c);
    if (go_m.exists(k)) begin
      d = go_m[k]; hit = 1;
      np = (m_path != 0) ? (m_path & pv_m[d]) : pv_m[d];
    end else begin
      r = (m_path != 0) ? fl_m[m_st] : 0;
      k = r * 256 + int'(c);
      if (go_m.exists(k)) begin d = go_m[k]; hit = 1; np = pv_m[d]; end
      else begin d = 0; hit = 0; np = '0; end
    end
    m_mvld = hit && fn_m[d] && (np != 0);
    m_mvec = m_mvld ? np : '0;
    m_st = d; m_path = np;
  endtask

  task automatic chk(input string tag);
    checks++;
    if (int'(state_o) != m_st || path_o != m_path || match_vld_o != m_mvld || match_o != m_mvec) begin
      fails++;
      $display("FAIL %s: got st=%0d path=%b mv=%b m=%b exp st=%0d path=%b mv=%b m=%b",
               tag, state_o, path_o, match_vld_o, match_o, m_st, m_path, m_mvld, m_mvec);
    end
  endtask

  task automatic expect_match(input bit ev, input logic [NP-1:0] em, input string tag);
    checks++;
    if (match_vld_o != ev || match_o != em) begin
      fails++;
      $display("FAIL %s: got mv=%b m=%b exp mv=%b m=%b", tag, match_vld_o, match_o, ev, em);
    end
  endtask

  task automatic step(input bit v, input logic [7:0] c, input string tag);
    chr_vld = v; chr = c;
    @(posedge clk);
    model_step(v, c);
    @(negedge clk);
    chr_vld = 1'b0;
    chk(tag);
  endtask

  task automatic feed(input string s, input string tag);
    for (int i = 0; i < s.len(); i++) step(1'b1, s[i], tag);
  endtask

  task automatic wr_tr(input int s, input logic [7:0] c, input int n);
    cfg_we = 1'b1; cfg_tbl = 1'b0; cfg_src = SW'(s); cfg_chr = c; cfg_nxt = SW'(n);
    @(negedge clk); cfg_we = 1'b0;
    go_m[s * 256 + int'(c)] = n;
  endtask

  task automatic wr_st(input int s, input int f, input logic [NP-1:0] p, input bit fin);
    cfg_we = 1'b1; cfg_tbl = 1'b1; cfg_src = SW'(s); cfg_fail = SW'(f); cfg_path = p; cfg_final = fin;
    @(negedge clk); cfg_we = 1'b0;
    fl_m[s] = f; pv_m[s] = p; fn_m[s] = fin;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: got no completion exp completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    chk("R1");
    expect_match(1'b0, '0, "R1");

    // R2: table load; patterns bit0 "bcdf", bit1 "pcdg" (shared cd), bit2 "dq"
    wr_st(0, 0, 4'b0000, 0);
    wr_st(1, 0, 4'b0001, 0);
    wr_st(2, 0, 4'b0010, 0);
    wr_st(3, 0, 4'b0011, 0);
    wr_st(4, 7, 4'b0011, 0);
    wr_st(5, 0, 4'b0001, 1);
    wr_st(6, 0, 4'b0010, 1);
    wr_st(7, 0, 4'b0100, 0);
    wr_st(8, 0, 4'b0100, 1);
    wr_tr(0, "b", 1); wr_tr(0, "p", 2); wr_tr(1, "c", 3); wr_tr(2, "c", 3);
    wr_tr(3, "d", 4); wr_tr(4, "f", 5); wr_tr(4, "g", 6);
    wr_tr(0, "d", 7); wr_tr(7, "q", 8);
    chk("R9");

    // R2: 'k' at root maps onto the slot of (1,'c') and must miss
    feed("k", "R2");
    expect_match(1'b0, '0, "R2");

    feed("pcdf", "R8");
    expect_match(1'b0, '0, "R8");
    // from dead end with path zero: restart from root (R6, R4)
    feed("dq", "R6");
    expect_match(1'b1, 4'b0100, "R7");

    step(1'b0, 8'h00, "R9");
    step(1'b0, 8'h00, "R9");

    feed("pcdg", "R8");
    expect_match(1'b1, 4'b0010, "R8");
    feed("x", "R6");

    feed("bcd", "R3");
    feed("f", "R7");
    expect_match(1'b1, 4'b0001, "R7");

    // R5: failure hop from shared 'd' state to "d" of pattern dq
    feed("xbcd", "R4");
    feed("q", "R5");
    expect_match(1'b1, 4'b0100, "R5");

    // R5: failure hop with miss returns to root
    feed("pcdd", "R5");
    feed("bcx", "R5");
    feed("dqdq", "R4");
    expect_match(1'b1, 4'b0100, "R4");

    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule